// File: doc/BRIEF.md
# Parallel NOR Flash Byte-Stream Reader

This block is a read-only master for an asynchronous parallel NOR flash that holds a configuration bitstream. It waits in idle until an init input goes from low to high. At that edge it looks at a 3-bit mode input. Only the byte-wide code starts a read; any other code leaves the reader idle.

A read starts at address zero. The block asserts its chip select and flash control lines and drives a serial-rate clock, `cfg_clk`, which it makes by dividing the system clock with a loadable divisor. The first address is held for a fixed number of slow clock periods. After that, the block captures one byte on every rising edge of `cfg_clk` and advances the address on every falling edge. Each captured byte leaves the block as a one-cycle valid pulse with its data, in address order.

A rate-update strobe loads a faster divisor partway through the stream. A read stops in one of three ways: a done input, an optional byte limit, or an active-low program input that aborts at once and then waits for a fresh init edge.

Top module: `flash_byte_reader`

## Requirements
- R1: After reset, `rom_cs_n`, every bit of `rom_lsel_n` and `rom_hsel_n` are 1, `rom_addr` is 0, `cfg_clk` is 0 and `out_valid` is 0.
- R2: A read starts only when `init_in` rises while idle, `prog_n` is high and `mode_in` equals 3'b010 at that edge; any other mode code leaves all outputs in the idle state.
- R3: The first byte is read from address 0 and each later byte from the next address up; byte k is delivered as the k-th `out_valid` pulse with `out_data` equal to the flash content at address k.
- R4: After a start, `rom_addr` stays 0 for exactly INIT_HOLD (default 5) full periods of the initial `cfg_clk`; the first byte is captured on the following rising edge, which is the (INIT_HOLD+1)-th rising edge of the run.
- R5: `rom_addr` changes only in the cycle `cfg_clk` falls. `out_valid` is a single-cycle pulse that appears in the cycle `cfg_clk` rises, carrying the byte present on `rom_data` at that edge.
- R6: At the start of every read, each half period of `cfg_clk` lasts INIT_DIV system clock cycles.
- R7: A `rate_upd` pulse during a read loads `rate_div` (with 0 treated as 1). The new half period takes effect at the next falling edge of `cfg_clk` and holds for the rest of the read.
- R8: `done_in` high during a read returns the block to idle one cycle later, with `rom_addr` at 0. While a read is running, changes on `init_in` and `mode_in` have no effect.
- R9: A nonzero `byte_limit` ends the read right after that many bytes have been delivered. A value of 0 sets no limit.
- R10: `prog_n` low aborts any read by the next cycle: `rom_cs_n` goes to 1 and `rom_addr` to 0. A new read then requires a fresh rising edge of `init_in`.
- R11: `rom_cs_n`, `rom_lsel_n` and `rom_hsel_n` are all 0 for the whole read, from the start through the hold window to the last byte, and all 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Active-low abort; holds the reader idle |
| init_in | input | 1 | Its rising edge requests a read |
| mode_in | input | MODE_W | Mode code, sampled at the init rising edge |
| done_in | input | 1 | Ends a read in progress |
| rate_upd | input | 1 | One-cycle strobe that loads `rate_div` |
| rate_div | input | DIV_W | New half-period divisor in system cycles |
| byte_limit | input | ADDR_W | Byte count that ends the read; 0 means no limit |
| rom_addr | output | ADDR_W | Flash byte address |
| rom_data | input | DATA_W | Flash data bus |
| rom_cs_n | output | 1 | Active-low chip select |
| rom_lsel_n | output | 3 | Active-low low-byte-lane controls |
| rom_hsel_n | output | 1 | Active-low high-byte-lane control |
| cfg_clk | output | 1 | Divided serial-rate clock |
| out_valid | output | 1 | One-cycle pulse per captured byte |
| out_data | output | DATA_W | Captured byte |

## Verification
The bench builds the block with a 4-bit divisor and an initial half period of 3 system cycles. This makes the five-period hold window 30 cycles long, so many complete reads fit in a short run. Rate updates from 0 to 4 exercise the clamp of 0 to 1. A divisor of 1 drives the tightest case, where the capture edge and the next address edge fall on back-to-back cycles. The address bus keeps its full 26-bit default, and limits from 1 to 14 reach the case where a read ends on its very first byte.

// File: rtl/frd_pkg.sv
package frd_pkg;

   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_HOLD = 2'd1,
      RD_READ = 2'd2
   } rd_state_t;

   localparam int LSEL_W = 3;

endpackage

// File: rtl/frd_clkgen.sv
module frd_clkgen #(
   parameter int DIV_W      = 8,
   parameter int INIT_DIV   = 16,
   parameter bit ALLOW_RATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             rate_upd,
   input  logic [DIV_W-1:0] rate_div,
   output logic             cfg_clk,
   output logic             rise_evt,
   output logic             fall_evt
);

   localparam logic [DIV_W-1:0] DIV_ONE  = DIV_W'(1);
   localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(INIT_DIV);

   logic [DIV_W-1:0] cur_div;
   logic [DIV_W-1:0] ph_cnt;
   logic             cclk_q;
   logic             tick;

   assign tick     = run && (ph_cnt == (cur_div - DIV_ONE));
   assign rise_evt = tick && !cclk_q;
   assign fall_evt = tick && cclk_q;
   assign cfg_clk  = cclk_q;

   // phase counter and clock level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_cnt <= '0;
         cclk_q <= 1'b0;
      end else if (!run) begin
         ph_cnt <= '0;
         cclk_q <= 1'b0;
      end else if (tick) begin
         ph_cnt <= '0;
         cclk_q <= ~cclk_q;
      end else begin
         ph_cnt <= ph_cnt + DIV_ONE;
      end
   end

   generate
      if (ALLOW_RATE) begin : g_rate
         logic [DIV_W-1:0] pend_div;
         logic             pend_vld;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cur_div  <= DIV_INIT;
               pend_div <= DIV_INIT;
               pend_vld <= 1'b0;
            end else if (restart) begin
               cur_div  <= DIV_INIT;
               pend_vld <= 1'b0;
            end else if (run) begin
               if (fall_evt && pend_vld) begin
                  cur_div  <= pend_div;
                  pend_vld <= 1'b0;
               end
               if (rate_upd) begin
                  pend_div <= (rate_div == '0) ? DIV_ONE : rate_div;
                  pend_vld <= 1'b1;
               end
            end
         end
      end else begin : g_fixed
         logic unused_rate;
         assign unused_rate = rate_upd ^ restart ^ (^rate_div);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cur_div <= DIV_INIT;
            else        cur_div <= DIV_INIT;
         end
      end
   endgenerate

endmodule

// File: rtl/frd_addr.sv
module frd_addr #(
   parameter int ADDR_W    = 26,
   parameter bit USE_LIMIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              idle_nxt,
   input  logic              inc,
   input  logic [ADDR_W-1:0] byte_limit,
   output logic [ADDR_W-1:0] rom_addr,
   output logic              last_byte
);

   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        addr_q <= '0;
      else if (idle_nxt) addr_q <= '0;
      else if (inc)      addr_q <= addr_q + ADDR_ONE;
   end

   assign rom_addr = addr_q;

   generate
      if (USE_LIMIT) begin : g_limit
         logic [ADDR_W-1:0] limit_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     limit_q <= '0;
            else if (start) limit_q <= byte_limit;
         end

         // the byte now captured is number addr_q+1 of the run
         assign last_byte = (limit_q != '0) && ((addr_q + ADDR_ONE) == limit_q);
      end else begin : g_nolimit
         logic unused_limit;
         assign unused_limit = (^byte_limit) ^ start;
         assign last_byte    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/frd_seq.sv
module frd_seq
   import frd_pkg::*;
#(
   parameter int              MODE_W    = 3,
   parameter logic [MODE_W-1:0] BYTE_MODE = 3'b010,
   parameter int              INIT_HOLD = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_n,
   input  logic              init_in,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              done_in,
   input  logic              rise_evt,
   input  logic              fall_evt,
   input  logic              last_byte,
   output logic              start,
   output logic              active,
   output logic              idle_nxt,
   output logic              cap,
   output logic              inc
);

   localparam int HC_W = (INIT_HOLD < 2) ? 1 : $clog2(INIT_HOLD);
   localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(INIT_HOLD - 1);

   rd_state_t       state_q, state_d;
   logic [HC_W-1:0] hold_cnt;
   logic            init_q;
   logic            init_rise;

   // edge detector; reset high so a level already high never starts a read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) init_q <= 1'b1;
      else        init_q <= init_in;
   end

   assign init_rise = init_in && !init_q;
   assign start     = (state_q == RD_IDLE) && prog_n && init_rise &&
                      (mode_in == BYTE_MODE);

   always_comb begin
      state_d = state_q;
      if (!prog_n) begin
         state_d = RD_IDLE;
      end else begin
         unique case (state_q)
            RD_IDLE: if (start) state_d = RD_HOLD;
            RD_HOLD: begin
               if (done_in)
                  state_d = RD_IDLE;
               else if (fall_evt && (hold_cnt == HOLD_LAST))
                  state_d = RD_READ;
            end
            RD_READ: begin
               if (done_in)
                  state_d = RD_IDLE;
               else if (rise_evt && last_byte)
                  state_d = RD_IDLE;
            end
            default: state_d = RD_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RD_IDLE;
         hold_cnt <= '0;
      end else begin
         state_q <= state_d;
         if (state_q != RD_HOLD)
            hold_cnt <= '0;
         else if (fall_evt)
            hold_cnt <= hold_cnt + HC_W'(1);
      end
   end

   assign active   = (state_q != RD_IDLE);
   assign idle_nxt = (state_d == RD_IDLE);
   assign cap      = (state_q == RD_READ) && rise_evt && !done_in && prog_n;
   assign inc      = (state_q == RD_READ) && fall_evt && !done_in && prog_n;

endmodule

// File: rtl/flash_byte_reader.sv
module flash_byte_reader
   import frd_pkg::*;
#(
   parameter int                ADDR_W     = 26,
   parameter int                DATA_W     = 8,
   parameter int                MODE_W     = 3,
   parameter logic [MODE_W-1:0] BYTE_MODE  = 3'b010,
   parameter int                DIV_W      = 8,
   parameter int                INIT_DIV   = 16,
   parameter int                INIT_HOLD  = 5,
   parameter bit                USE_LIMIT  = 1'b1,
   parameter bit                ALLOW_RATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_n,
   input  logic              init_in,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              done_in,
   input  logic              rate_upd,
   input  logic [DIV_W-1:0]  rate_div,
   input  logic [ADDR_W-1:0] byte_limit,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_data,
   output logic              rom_cs_n,
   output logic [2:0]        rom_lsel_n,
   output logic              rom_hsel_n,
   output logic              cfg_clk,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   // elaboration checks
   if (INIT_DIV < 1 || INIT_DIV >= (1 << DIV_W)) begin : g_bad_div
      $error("INIT_DIV must lie in 1 .. 2**DIV_W-1");
   end
   if (INIT_HOLD < 1) begin : g_bad_hold
      $error("INIT_HOLD must be at least 1");
   end
   if (ADDR_W < 2 || DATA_W < 1 || MODE_W < 1) begin : g_bad_width
      $error("ADDR_W, DATA_W and MODE_W are too small");
   end

   logic start, active, idle_nxt, cap, inc, last_byte;
   logic rise_evt, fall_evt;

   frd_seq #(
      .MODE_W    (MODE_W),
      .BYTE_MODE (BYTE_MODE),
      .INIT_HOLD (INIT_HOLD)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_n    (prog_n),
      .init_in   (init_in),
      .mode_in   (mode_in),
      .done_in   (done_in),
      .rise_evt  (rise_evt),
      .fall_evt  (fall_evt),
      .last_byte (last_byte),
      .start     (start),
      .active    (active),
      .idle_nxt  (idle_nxt),
      .cap       (cap),
      .inc       (inc)
   );

   frd_clkgen #(
      .DIV_W      (DIV_W),
      .INIT_DIV   (INIT_DIV),
      .ALLOW_RATE (ALLOW_RATE)
   ) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (active),
      .restart  (start),
      .rate_upd (rate_upd),
      .rate_div (rate_div),
      .cfg_clk  (cfg_clk),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   frd_addr #(
      .ADDR_W    (ADDR_W),
      .USE_LIMIT (USE_LIMIT)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .idle_nxt   (idle_nxt),
      .inc        (inc),
      .byte_limit (byte_limit),
      .rom_addr   (rom_addr),
      .last_byte  (last_byte)
   );

   // byte capture at the cycle cfg_clk rises
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= cap;
         if (cap) out_data <= rom_data;
      end
   end

   assign rom_cs_n   = !active;
   assign rom_lsel_n = {LSEL_W{!active}};
   assign rom_hsel_n = !active;

endmodule

// File: rtl/frd_checker.sv
module frd_checker #(
   parameter int ADDR_W = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prog_n,
   input logic              done_in,
   input logic [ADDR_W-1:0] rom_addr,
   input logic              rom_cs_n,
   input logic              cfg_clk,
   input logic              out_valid
);

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_addr != $past(rom_addr)) |->
         ((rom_addr == $past(rom_addr) + ADDR_W'(1)) || (rom_addr == '0)));

   assert_start_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rom_cs_n) |-> (rom_addr == '0));

   assert_addr_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((rom_addr != $past(rom_addr)) && (rom_addr != '0)) |-> $fell(cfg_clk));

   assert_valid_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $rose(cfg_clk));

   assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_done_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_in && prog_n && !rom_cs_n) |=> (rom_cs_n && (rom_addr == '0)));

   assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n |=> (rom_cs_n && (rom_addr == '0)));

   assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_cs_n && $past(rom_cs_n)) |-> !out_valid);

endmodule

bind flash_byte_reader frd_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .prog_n    (prog_n),
   .done_in   (done_in),
   .rom_addr  (rom_addr),
   .rom_cs_n  (rom_cs_n),
   .cfg_clk   (cfg_clk),
   .out_valid (out_valid)
);

// File: tb/flash_byte_reader_bench.sv
module flash_byte_reader_bench;

   localparam int ADDR_W    = 26;
   localparam int DATA_W    = 8;
   localparam int DIV_W     = 4;
   localparam int INIT_DIV  = 3;
   localparam int INIT_HOLD = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              prog_n = 1'b1;
   logic              init_in = 1'b0;
   logic [2:0]        mode_in = 3'b000;
   logic              done_in = 1'b0;
   logic              rate_upd = 1'b0;
   logic [DIV_W-1:0]  rate_div = '0;
   logic [ADDR_W-1:0] byte_limit = '0;
   logic [ADDR_W-1:0] rom_addr;
   logic [DATA_W-1:0] rom_data;
   logic              rom_cs_n;
   logic [2:0]        rom_lsel_n;
   logic              rom_hsel_n;
   logic              cfg_clk;
   logic              out_valid;
   logic [DATA_W-1:0] out_data;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   function automatic logic [7:0] byte_of(input logic [ADDR_W-1:0] a);
      return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
   endfunction

   assign rom_data = byte_of(rom_addr);

   flash_byte_reader #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .DIV_W     (DIV_W),
      .INIT_DIV  (INIT_DIV),
      .INIT_HOLD (INIT_HOLD)
   ) u_flash_byte_reader (
      .clk        (clk),
      .rst_n      (rst_n),
      .prog_n     (prog_n),
      .init_in    (init_in),
      .mode_in    (mode_in),
      .done_in    (done_in),
      .rate_upd   (rate_upd),
      .rate_div   (rate_div),
      .byte_limit (byte_limit),
      .rom_addr   (rom_addr),
      .rom_data   (rom_data),
      .rom_cs_n   (rom_cs_n),
      .rom_lsel_n (rom_lsel_n),
      .rom_hsel_n (rom_hsel_n),
      .cfg_clk    (cfg_clk),
      .out_valid  (out_valid),
      .out_data   (out_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // output monitor: byte order, data, hold window
   int exp_idx = 0;
   int vcount = 0;
   int rises_run = 0;
   bit hold_bad = 1'b0;
   logic prev_cs = 1'b1;
   logic prev_clk = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_cs && !rom_cs_n) begin
            exp_idx   = 0;
            rises_run = 0;
            hold_bad  = 1'b0;
         end
         if (!prev_clk && cfg_clk) rises_run++;
         if (!rom_cs_n && rises_run < INIT_HOLD + 1 && rom_addr != '0) hold_bad = 1'b1;
         if (out_valid) begin
            vcount++;
            check(out_data == byte_of(ADDR_W'(exp_idx)), "R3 byte data",
                  int'(out_data), int'(byte_of(ADDR_W'(exp_idx))));
            if (!rom_cs_n)
               check(rom_addr == ADDR_W'(exp_idx), "R5 address at capture",
                     int'(rom_addr), exp_idx);
            if (exp_idx == 0) begin
               check(rises_run == INIT_HOLD + 1, "R4 first capture edge",
                     rises_run, INIT_HOLD + 1);
               check(!hold_bad, "R4 address held at zero", int'(hold_bad), 0);
            end
            exp_idx++;
         end
         prev_cs  = rom_cs_n;
         prev_clk = cfg_clk;
      end
   end

   task automatic start_pulse(input logic [2:0] code);
      init_in = 1'b0;
      @(negedge clk);
      mode_in = code;
      init_in = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_idx(input int n);
      while (exp_idx < n) @(negedge clk);
   endtask

   task automatic measure_high(output int n);
      while (cfg_clk) @(negedge clk);
      while (!cfg_clk) @(negedge clk);
      n = 0;
      while (cfg_clk) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic rate_change(input int d);
      int n;
      int eff;
      eff = (d == 0) ? 1 : d;
      while (!cfg_clk) @(negedge clk);
      rate_div = DIV_W'(d);
      rate_upd = 1'b1;
      @(negedge clk);
      rate_upd = 1'b0;
      measure_high(n);
      check(n == eff, "R7 half period after rate update", n, eff);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      int v0;
      int lim;
      int d;
      void'($urandom(32'h5EED_0042));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(rom_cs_n == 1'b1, "R1 chip select idle", int'(rom_cs_n), 1);
      check(rom_lsel_n == 3'b111 && rom_hsel_n, "R1 lane controls idle",
            int'({rom_hsel_n, rom_lsel_n}), 15);
      check(rom_addr == '0, "R1 address zero", int'(rom_addr), 0);
      check(!cfg_clk && !out_valid, "R1 clock and valid low",
            int'({cfg_clk, out_valid}), 0);

      // R2 wrong mode codes keep the reader idle
      for (int i = 0; i < 4; i++) begin
         logic [2:0] c;
         c = 3'($urandom_range(0, 7));
         if (c == 3'b010) c = 3'b101;
         v0 = vcount;
         start_pulse(c);
         repeat (80) @(negedge clk);
         check(rom_cs_n && rom_addr == '0, "R2 non-byte mode stays idle",
               int'(rom_cs_n), 1);
         check(vcount == v0, "R2 no bytes in wrong mode", vcount, v0);
      end

      // directed run: unlimited, initial rate, ignore, rate change, done
      byte_limit = '0;
      start_pulse(3'b010);
      check(rom_cs_n == 1'b0 && rom_lsel_n == 3'b000 && !rom_hsel_n,
            "R11 controls asserted in hold", int'({rom_hsel_n, rom_lsel_n, rom_cs_n}), 0);
      measure_high(n);
      check(n == INIT_DIV, "R6 initial half period", n, INIT_DIV);
      wait_idx(4);
      init_in = 1'b0;
      mode_in = 3'($urandom_range(0, 7));
      repeat (3) @(negedge clk);
      init_in = 1'b1;
      mode_in = 3'b111;
      repeat (3) @(negedge clk);
      check(rom_cs_n == 1'b0, "R8 init and mode ignored while reading",
            int'(rom_cs_n), 0);
      rate_change(1);
      wait_idx(exp_idx + 6);
      check(rom_lsel_n == 3'b000 && !rom_hsel_n, "R11 controls asserted in read",
            int'({rom_hsel_n, rom_lsel_n}), 0);
      rate_change(0);
      wait_idx(exp_idx + 3);
      done_in = 1'b1;
      @(negedge clk);
      check(rom_cs_n && rom_addr == '0 && rom_lsel_n == 3'b111 && rom_hsel_n,
            "R8 done releases the flash", int'(rom_cs_n), 1);
      done_in = 1'b0;
      v0 = vcount;
      repeat (40) @(negedge clk);
      check(vcount == v0 && rom_cs_n, "R8 no bytes after done", vcount, v0);

      // R10 abort mid read
      start_pulse(3'b010);
      wait_idx(3);
      prog_n = 1'b0;
      @(negedge clk);
      check(rom_cs_n && rom_addr == '0, "R10 abort releases at once",
            int'(rom_addr), 0);
      prog_n = 1'b1;
      v0 = vcount;
      repeat (60) @(negedge clk);
      check(rom_cs_n && vcount == v0, "R10 no restart without new init edge",
            int'(rom_cs_n), 1);
      start_pulse(3'b010);
      wait_idx(2);
      check(rom_cs_n == 1'b0, "R10 restart after fresh init edge", int'(rom_cs_n), 0);
      done_in = 1'b1;
      @(negedge clk);
      done_in = 1'b0;

      // R9 limit of a single byte
      byte_limit = ADDR_W'(1);
      start_pulse(3'b010);
      while (!rom_cs_n) @(negedge clk);
      repeat (20) @(negedge clk);
      check(exp_idx == 1 && rom_cs_n, "R9 limit of one byte", exp_idx, 1);

      // random runs with limits and rate updates
      for (int r = 0; r < 8; r++) begin
         lim = $urandom_range(5, 14);
         d   = $urandom_range(0, 4);
         byte_limit = ADDR_W'(lim);
         start_pulse(3'b010);
         wait_idx(1);
         rate_change(d);
         while (!rom_cs_n) @(negedge clk);
         repeat (12) @(negedge clk);
         check(exp_idx == lim, "R9 byte count at limit", exp_idx, lim);
         check(rom_addr == '0 && !cfg_clk, "R9 idle after limit",
               int'(rom_addr), 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule